// File: doc/BRIEF.md
# Accumulator Machine Execution Core

This block is a compact one-address processor. It runs an endless fetch, decode and execute loop against one synchronous memory that holds both the program and its data. Each 16-bit instruction names one operation and one memory operand address. A single accumulator register supplies the other operand and receives every arithmetic result. The available operations are load, store, add, subtract and multiply, plus a halt that stops the core until reset.

The memory port has an address, a write strobe, write data and read data. Read data comes back one cycle after the address is presented. Because of that latency, every instruction takes exactly three cycles. In the first cycle the instruction address goes out. In the second the instruction word arrives, is decoded, and the operand address goes out. In the third the operand word is combined with the accumulator, or the accumulator is written to memory. A halted flag and the accumulator value are available as outputs for observation.

Top module: `acc_core`

## Requirements
- R1: While reset is held, and in the first cycle after it, `halted` is 0, `acc_out` is 0, `mem_we` is 0 and `mem_addr` is 0, so the first instruction is fetched from address 0.
- R2: An instruction word carries its opcode in bits 15:12 and its operand address in bits 11:0. Each instruction takes three cycles. The program counter is presented as the fetch address and then advances by one, so a program whose halt sits at word k raises `halted` 3k+2 clock edges after reset is released.
- R3: Opcode 0 (load) replaces the accumulator with the memory word at the operand address.
- R4: Opcode 1 (store) writes the accumulator to the operand address with `mem_we` high for exactly one cycle, and that value can be read back by a later load.
- R5: Opcode 2 (add) sets the accumulator to accumulator plus operand, modulo 2^16.
- R6: Opcode 3 (sub) sets the accumulator to accumulator minus operand (accumulator first), modulo 2^16.
- R7: Opcode 4 (mult) sets the accumulator to the low 16 bits of accumulator times operand.
- R8: Opcode 15 (halt) raises `halted` and holds it until reset. While halted, `mem_addr` stays frozen, no write is issued and the accumulator does not change.
- R9: Opcodes 5 to 14 leave the accumulator and memory untouched, and execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | ADDR_W (12) | Memory word address for the current cycle |
| mem_we | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | DATA_W (16) | Data to write (accumulator) |
| mem_rdata | input | DATA_W (16) | Read data, valid one cycle after its address |
| halted | output | 1 | Core has executed a halt |
| acc_out | output | DATA_W (16) | Current accumulator value |

## Verification
A corrupt program counter or sequencer state shows up immediately as a wrong fetch address, and it also moves the cycle at which `halted` rises, which the bench measures exactly. A wrong accumulator value becomes visible at the next store, three to six cycles later. That is why the test programs store after every arithmetic step. A halt that is not sticky, or an undefined opcode that is not ignored, shows up as an unexpected write, a moving address or a changed `acc_out` within a few cycles.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [1:0] {
      ST_FETCH  = 2'd0,
      ST_DECODE = 2'd1,
      ST_EXEC   = 2'd2,
      ST_HALT   = 2'd3
   } core_state_t;

   localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h0;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'h1;
   localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
   localparam logic [OPC_W-1:0] OPC_SUB   = 4'h3;
   localparam logic [OPC_W-1:0] OPC_MUL   = 4'h4;
   localparam logic [OPC_W-1:0] OPC_HALT  = 4'hF;

   // true when the opcode does anything at all in the execute cycle
   function automatic logic opc_known(input logic [OPC_W-1:0] opc);
      return (opc == OPC_LOAD) || (opc == OPC_STORE) || (opc == OPC_ADD) ||
             (opc == OPC_SUB)  || (opc == OPC_MUL)   || (opc == OPC_HALT);
   endfunction

endpackage

// File: rtl/acc_core_seq.sv
module acc_core_seq
   import acc_core_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [OPC_W-1:0]     exec_opc,
   output logic                 exec_cyc,
   output logic                 halted
);

   localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

   core_state_t         state_q;
   logic [ADDR_W-1:0]   pc_q;
   logic [OPC_W-1:0]    ir_opc_q;
   logic [ADDR_W-1:0]   ir_addr_q;
   logic [OPC_W-1:0]    fetched_opc;

   assign fetched_opc = mem_rdata[DATA_W-1 -: OPC_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_FETCH;
         pc_q      <= '0;
         ir_opc_q  <= '0;
         ir_addr_q <= '0;
      end else begin
         unique case (state_q)
            ST_FETCH: begin
               pc_q    <= pc_q + PC_STEP;
               state_q <= ST_DECODE;
            end
            ST_DECODE: begin
               ir_opc_q  <= fetched_opc;
               ir_addr_q <= mem_rdata[ADDR_W-1:0];
               state_q   <= (fetched_opc == OPC_HALT) ? ST_HALT : ST_EXEC;
            end
            ST_EXEC: begin
               state_q <= ST_FETCH;
            end
            default: begin
               state_q <= ST_HALT;
            end
         endcase
      end
   end

   // operand address goes out during decode so the word lands in execute
   always_comb begin
      unique case (state_q)
         ST_DECODE: mem_addr = mem_rdata[ADDR_W-1:0];
         ST_EXEC:   mem_addr = ir_addr_q;
         default:   mem_addr = pc_q;
      endcase
   end

   assign exec_opc = ir_opc_q;
   assign exec_cyc = (state_q == ST_EXEC);
   assign halted   = (state_q == ST_HALT);

   // R2
   fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH) |=> (pc_q == $past(pc_q) + PC_STEP));

   // R2
   decode_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DECODE) |-> ($past(state_q) == ST_FETCH));

   // R8
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT) |=> ((state_q == ST_HALT) && $stable(pc_q)));

endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
   import acc_core_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int MUL_IMPL = 0
) (
   input  logic [OPC_W-1:0]  opc,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opnd,
   output logic              acc_wr,
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] prod;

   generate
      if (MUL_IMPL == 0) begin : g_mul_native
         assign prod = acc * opnd;
      end else begin : g_mul_shift
         always_comb begin
            prod = '0;
            for (int i = 0; i < DATA_W; i++) begin
               if (opnd[i]) prod = prod + (acc << i);
            end
         end
      end
   endgenerate

   always_comb begin
      acc_wr = 1'b1;
      result = acc;
      unique case (opc)
         OPC_LOAD: result = opnd;
         OPC_ADD:  result = acc + opnd;
         OPC_SUB:  result = acc - opnd;
         OPC_MUL:  result = prod;
         default:  acc_wr = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_core_accum.sv
module acc_core_accum #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] value
);

   always_ff @(posedge clk) begin
      if (!rst_n)     value <= '0;
      else if (wr_en) value <= wr_data;
   end

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 12,
   parameter int MUL_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted,
   output logic [DATA_W-1:0] acc_out
);

   localparam int INSN_W = OPC_W + ADDR_W;

   generate
      if (INSN_W != DATA_W) begin : g_bad_width
         $error("acc_core: opcode plus address must fill one data word");
      end
      if (MUL_IMPL != 0 && MUL_IMPL != 1) begin : g_bad_mul
         $error("acc_core: MUL_IMPL must be 0 or 1");
      end
   endgenerate

   logic [OPC_W-1:0]  exec_opc;
   logic              exec_cyc;
   logic              alu_wr;
   logic [DATA_W-1:0] alu_res;
   logic [DATA_W-1:0] acc_q;

   acc_core_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mem_rdata(mem_rdata),
      .mem_addr (mem_addr),
      .exec_opc (exec_opc),
      .exec_cyc (exec_cyc),
      .halted   (halted)
   );

   acc_core_alu #(.DATA_W(DATA_W), .MUL_IMPL(MUL_IMPL)) u_alu (
      .opc   (exec_opc),
      .acc   (acc_q),
      .opnd  (mem_rdata),
      .acc_wr(alu_wr),
      .result(alu_res)
   );

   acc_core_accum #(.DATA_W(DATA_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (exec_cyc && alu_wr),
      .wr_data(alu_res),
      .value  (acc_q)
   );

   assign mem_we    = exec_cyc && (exec_opc == OPC_STORE);
   assign mem_wdata = acc_q;
   assign acc_out   = acc_q;

   // R4
   one_cycle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R8
   halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_we);

   // R8
   halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(mem_addr) && $stable(acc_out)));

   // R9
   undef_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_cyc && !opc_known(exec_opc)) |=> ($stable(acc_out) && !mem_we));

endmodule

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic        mem_we;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        halted;
   logic [15:0] acc_out;

   int checks = 0;
   int errors = 0;
   logic [15:0] mem [0:255];

   typedef struct {
      logic [11:0] a;
      logic [15:0] d;
      string       req;
   } wr_item_t;
   wr_item_t exp_q[$];

   always #2.5 clk = ~clk;

   acc_core u0 (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted),
      .acc_out(acc_out)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: compare each write against the scoreboard
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R4", "unexpected write", {4'h0, mem_addr, mem_wdata}, 32'h0);
         end else begin
            wr_item_t it;
            it = exp_q.pop_front();
            check(mem_addr == it.a && mem_wdata == it.d, it.req, "store",
                  {4'h0, mem_addr, mem_wdata}, {4'h0, it.a, it.d});
         end
      end
   end

   task automatic expect_write(input logic [11:0] a, input logic [15:0] d, input string req);
      wr_item_t it;
      it.a = a; it.d = d; it.req = req;
      exp_q.push_back(it);
   endtask

   function automatic logic [15:0] insn(input logic [3:0] op, input logic [11:0] a);
      return {op, a};
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
   endtask

   task automatic reset_core();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1
      check(!halted && acc_out == 16'h0 && !mem_we && mem_addr == 12'h0, "R1",
            "state in reset", {halted, mem_we, 2'b0, mem_addr, acc_out}, 32'h0);
      rst_n = 1'b1;
   endtask

   // counts edges from reset release to halted; checks three cycles per word
   task automatic run_to_halt(input int exp_edges, input string req);
      int n = 0;
      // R1
      check(mem_addr == 12'h0 && !halted, "R1", "first fetch address", mem_addr, 0);
      while (!halted && n < 400) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      check(n == exp_edges, req, "edges to halt", n, exp_edges);
   endtask

   task automatic check_frozen(input logic [15:0] exp_acc, input logic [7:0] unused_loc);
      logic [11:0] a0;
      bit ok = 1'b1;
      a0 = mem_addr;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (mem_addr != a0 || !halted || mem_we || acc_out != exp_acc) ok = 1'b0;
      end
      // R8
      check(ok, "R8", "frozen while halted", {4'h0, mem_addr, acc_out}, {4'h0, a0, exp_acc});
      check(mem[unused_loc] == 16'h0, "R8", "word after halt not run", mem[unused_loc], 0);
      check(exp_q.size() == 0, "R4", "all expected stores seen", exp_q.size(), 0);
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // program A: arithmetic, wraps, undefined opcode, halt at word 13
      clear_mem();
      mem[8'h80] = 16'h0007; mem[8'h81] = 16'hFFFE; mem[8'h82] = 16'h0003;
      mem[8'h83] = 16'h1234; mem[8'h84] = 16'h0100;
      mem[0]  = insn(4'h0, 12'h080);   // R3 load 7
      mem[1]  = insn(4'h1, 12'h090);
      mem[2]  = insn(4'h2, 12'h081);   // R5 7 + FFFE
      mem[3]  = insn(4'h1, 12'h091);
      mem[4]  = insn(4'h3, 12'h082);   // R6 5 - 3
      mem[5]  = insn(4'h1, 12'h092);
      mem[6]  = insn(4'h3, 12'h080);   // R6 2 - 7 wraps
      mem[7]  = insn(4'h1, 12'h093);
      mem[8]  = insn(4'h0, 12'h083);
      mem[9]  = insn(4'h4, 12'h084);   // R7 1234 * 100
      mem[10] = insn(4'h1, 12'h094);
      mem[11] = insn(4'h7, 12'h080);   // R9 undefined
      mem[12] = insn(4'h1, 12'h095);
      mem[13] = insn(4'hF, 12'h000);
      mem[14] = insn(4'h1, 12'h096);
      expect_write(12'h090, 16'h0007, "R3");
      expect_write(12'h091, 16'h0005, "R5");
      expect_write(12'h092, 16'h0002, "R6");
      expect_write(12'h093, 16'hFFFB, "R6");
      expect_write(12'h094, 16'h3400, "R7");
      expect_write(12'h095, 16'h3400, "R9");
      reset_core();
      run_to_halt(41, "R2");
      check(acc_out == 16'h3400, "R9", "acc after undefined opcode", acc_out, 16'h3400);
      check(mem_addr == 12'h00E, "R8", "halt address", mem_addr, 12'h00E);
      check_frozen(16'h3400, 8'h96);

      // program B: full-width multiply, store then reload, add wrap to zero
      clear_mem();
      mem[8'h80] = 16'hFFFF; mem[8'h81] = 16'h7FFF;
      mem[0] = insn(4'h0, 12'h080);
      mem[1] = insn(4'h4, 12'h080);    // R7 FFFF*FFFF low half = 1
      mem[2] = insn(4'h1, 12'h090);
      mem[3] = insn(4'h2, 12'h081);    // 1 + 7FFF = 8000
      mem[4] = insn(4'h1, 12'h081);    // R4 overwrite operand
      mem[5] = insn(4'h2, 12'h081);    // R5 8000 + 8000 = 0
      mem[6] = insn(4'h1, 12'h091);
      mem[7] = insn(4'h0, 12'h081);    // R4 reload stored value
      mem[8] = insn(4'h1, 12'h092);
      mem[9] = insn(4'hF, 12'h000);
      mem[10] = insn(4'h1, 12'h093);
      expect_write(12'h090, 16'h0001, "R7");
      expect_write(12'h081, 16'h8000, "R4");
      expect_write(12'h091, 16'h0000, "R5");
      expect_write(12'h092, 16'h8000, "R4");
      reset_core();
      run_to_halt(29, "R2");
      check(acc_out == 16'h8000, "R3", "acc after reload", acc_out, 16'h8000);
      check(mem[8'h81] == 16'h8000, "R4", "stored word in memory", mem[8'h81], 16'h8000);
      check_frozen(16'h8000, 8'h93);

      // R1 reset from halted clears the core and it restarts at word 0
      reset_core();
      @(negedge clk);
      check(!halted, "R1", "halted cleared by reset", halted, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule